// File: doc/BRIEF.md
# Banked Pin Output and Polarity Controller

This block owns a bank of general-purpose pins and exposes them through a small memory-mapped register window driven by a single request strobe. Software changes the shared output latch only through two write-one masks, one that raises bits and one that lowers them. Each pin also has its own configuration word. That word holds a direction bit, a polarity inverter, an open-drain selector and a function-select field. A nonzero function-select field hands the pad to another on-chip function. The pad inputs pass through a synchronizer and can be read back as raw levels.

Pins are grouped 64 to a bank. Bank `b` keeps its input, set and clear registers at `b * 0x1400` plus the usual offset, and pin `p` lives in bank `p / 64` at bit `p % 64`. The configuration words form one linear array indexed by pin number. Reads are answered by a two-state access sequencer. In `ST_IDLE`, an accepted read moves it to `ST_RESP` (transition *read-accept*). In `ST_RESP`, `rd_valid` is high. Another read keeps it in `ST_RESP` (transition *read-chain*), and any other cycle returns it to `ST_IDLE` (transition *read-done*). A write never leaves `ST_IDLE`.

Top module: `gpio_bank`

## Requirements
- R1: While reset is held, and after it is released with no write made, the output latch and every configuration word are zero, every pad has `pad_oe` low, and `rd_valid` is low.
- R2: A write to the set register of a bank (offset 0x8) sets to 1 every latch bit whose written bit is 1 and leaves the other latch bits unchanged. A read of offset 0x8 or 0x10 returns the bank's current latch.
- R3: A write to the clear register (offset 0x10) sets to 0 every latch bit whose written bit is 1 and leaves the other latch bits unchanged.
- R4: Writing all zeros to the set register or to the clear register leaves the latch and the pads unchanged.
- R5: A read of offset 0x0 returns the pad levels after a two-flop synchronizer, with no polarity inversion applied. Any read returns `rd_data` together with `rd_valid` high in the cycle after it is accepted.
- R6: The word for pin `p` sits at 0x400 + 8·p. Its fields are bit 0 output enable, bit 1 polarity invert, bit 12 open-drain, and bits 25:16 function select. A read returns these fields, and every other bit reads 0.
- R7: For a GPIO pin (function select zero) that is not in open-drain mode, `pad_oe` equals the output enable and `pad_out` equals the latch bit XOR the invert bit.
- R8: For a GPIO pin in open-drain mode, `pad_out` is 0, and `pad_oe` is high only when the output enable is set and the latch bit XOR the invert bit is 0.
- R9: For a pin whose function select is nonzero, `pad_out` follows `fn_out` and `pad_oe` follows `fn_oe`, whatever the latch and the other configuration bits hold.
- R10: Offset 0x90 reads the pin count in bits 7:0 and `IRQ_BASE` in bits 15:8, with all other bits 0.
- R11: Bank `b` registers sit at `b * 0x1400` plus their offset. Bit positions above the last implemented pin read 0, and writes to them are ignored.
- R12: Reads of unmapped or unaligned addresses return 0. Writes to the input register, the constant register and unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 64 | Read data |
| pad_in | input | NUM_PINS | Pad input levels |
| pad_out | output | NUM_PINS | Pad output data |
| pad_oe | output | NUM_PINS | Pad output enable |
| fn_out | input | NUM_PINS | Output data from the alternate function |
| fn_oe | input | NUM_PINS | Output enable from the alternate function |

## Verification
The bench builds the block with 80 pins, an interrupt base of 48 and a 16-bit address. With 80 pins there is one full bank and a second bank holding only 16 pins. That brings the bank stride, the `p / 64` mapping and the masking of unimplemented bits in bank 1 within reach. Random configuration words cover every mix of invert, open-drain and function select across both banks. Random set and clear masks stress the latch, and a model of the pads is compared after every operation.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BANK_W       = 64;
    localparam int BANK_STRIDE  = 'h1400;
    localparam int OFF_IN       = 'h0;
    localparam int OFF_SET      = 'h8;
    localparam int OFF_CLR      = 'h10;
    localparam int OFF_CONST    = 'h90;
    localparam int CFG_BASE     = 'h400;
    localparam int CFG_STRIDE   = 8;

    localparam int FLD_OE       = 0;
    localparam int FLD_INV      = 1;
    localparam int FLD_OD       = 12;
    localparam int FLD_SEL_LO   = 16;
    localparam int FLD_SEL_W    = 10;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_IN,
        ACC_SET,
        ACC_CLR,
        ACC_CONST,
        ACC_CFG
    } acc_kind_e;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_RESP
    } bus_state_e;

    typedef struct packed {
        logic [FLD_SEL_W-1:0] sel;
        logic                 od;
        logic                 inv;
        logic                 oe;
    } pin_cfg_t;

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NUM_PINS   = 80,
    parameter int NBANK      = 2,
    parameter int PIN_IDX_W  = 7,
    parameter int BANK_IDX_W = 1
) (
    input  logic [ADDR_W-1:0]     addr,
    output acc_kind_e             kind,
    output logic [BANK_IDX_W-1:0] bank,
    output logic [PIN_IDX_W-1:0]  pin
);
    localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + CFG_STRIDE * NUM_PINS);
    localparam logic [ADDR_W-1:0] CONST_A = ADDR_W'(OFF_CONST);

    logic [ADDR_W-1:0] cfg_off;

    always_comb begin
        kind    = ACC_NONE;
        bank    = '0;
        pin     = '0;
        cfg_off = addr - CFG_LO;
        if (addr[2:0] == 3'b000) begin
            if (addr >= CFG_LO && addr < CFG_HI) begin
                kind = ACC_CFG;
                pin  = PIN_IDX_W'(cfg_off >> 3);
            end else if (addr == CONST_A) begin
                kind = ACC_CONST;
            end else begin
                for (int b = 0; b < NBANK; b++) begin
                    if (addr == ADDR_W'(b * BANK_STRIDE + OFF_IN)) begin
                        kind = ACC_IN;
                        bank = BANK_IDX_W'(b);
                    end else if (addr == ADDR_W'(b * BANK_STRIDE + OFF_SET)) begin
                        kind = ACC_SET;
                        bank = BANK_IDX_W'(b);
                    end else if (addr == ADDR_W'(b * BANK_STRIDE + OFF_CLR)) begin
                        kind = ACC_CLR;
                        bank = BANK_IDX_W'(b);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int WIDTH  = 80,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_pin.sv
module gpio_bank_pin
    import gpio_bank_pkg::*;
(
    input  pin_cfg_t cfg,
    input  logic     latch_bit,
    input  logic     fn_out,
    input  logic     fn_oe,
    output logic     pad_out,
    output logic     pad_oe
);
    logic gpio_mode;
    logic level;

    assign gpio_mode = (cfg.sel == '0);
    assign level     = latch_bit ^ cfg.inv;

    always_comb begin
        if (!gpio_mode) begin
            // Pad belongs to the alternate function (R9)
            pad_out = fn_out;
            pad_oe  = fn_oe;
        end else if (cfg.od) begin
            // Open drain: pull low or float (R8)
            pad_out = 1'b0;
            pad_oe  = cfg.oe & ~level;
        end else begin
            // Push-pull (R7)
            pad_out = level;
            pad_oe  = cfg.oe;
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS    = 80,
    parameter int ADDR_W      = 16,
    parameter int IRQ_BASE    = 48,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [63:0]         req_wdata,
    output logic                rd_valid,
    output logic [63:0]         rd_data,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    input  logic [NUM_PINS-1:0] fn_out,
    input  logic [NUM_PINS-1:0] fn_oe
);
    localparam int NBANK      = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int BANK_IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int PIN_IDX_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int LOW_W      = (NUM_PINS < BANK_W) ? NUM_PINS : BANK_W;

    acc_kind_e             dec_kind;
    logic [BANK_IDX_W-1:0] dec_bank;
    logic [PIN_IDX_W-1:0]  dec_pin;

    bus_state_e            state_q, state_d;
    logic [NUM_PINS-1:0]   out_q, out_d;
    pin_cfg_t              cfg_q [NUM_PINS];
    logic [NUM_PINS-1:0]   in_sync;
    logic [63:0]           rd_next, rd_q;
    logic                  wr_acc, rd_acc;

    assign wr_acc = req_valid &&  req_write;
    assign rd_acc = req_valid && !req_write;

    gpio_bank_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_PINS  (NUM_PINS),
        .NBANK     (NBANK),
        .PIN_IDX_W (PIN_IDX_W),
        .BANK_IDX_W(BANK_IDX_W)
    ) u_decode (
        .addr(req_addr),
        .kind(dec_kind),
        .bank(dec_bank),
        .pin (dec_pin)
    );

    gpio_bank_sync #(
        .WIDTH (NUM_PINS),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (in_sync)
    );

    // Access sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Access sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_acc) state_d = ST_RESP;          // read-accept
            ST_RESP: state_d = rd_acc ? ST_RESP : ST_IDLE;   // read-chain / read-done
            default: state_d = ST_IDLE;
        endcase
    end

    // Access sequencer: outputs
    always_comb begin
        rd_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: rd_valid = 1'b0;
            ST_RESP: rd_valid = 1'b1;
            default: rd_valid = 1'b0;
        endcase
    end
    assign rd_data = rd_valid ? rd_q : '0;

    // Output latch next value through set / clear masks (R2, R3, R11)
    always_comb begin
        out_d = out_q;
        if (wr_acc) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (dec_bank == BANK_IDX_W'(p / BANK_W) && req_wdata[p % BANK_W]) begin
                    if (dec_kind == ACC_SET) out_d[p] = 1'b1;
                    if (dec_kind == ACC_CLR) out_d[p] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    // Configuration words (R6)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PINS; p++) cfg_q[p] <= '0;
        end else if (wr_acc && dec_kind == ACC_CFG) begin
            cfg_q[dec_pin] <= '{sel: req_wdata[FLD_SEL_LO +: FLD_SEL_W],
                                od : req_wdata[FLD_OD],
                                inv: req_wdata[FLD_INV],
                                oe : req_wdata[FLD_OE]};
        end
    end

    // Read data selection (R2, R5, R6, R10, R12)
    always_comb begin
        rd_next = '0;
        case (dec_kind)
            ACC_IN: begin
                for (int p = 0; p < NUM_PINS; p++)
                    if (dec_bank == BANK_IDX_W'(p / BANK_W)) rd_next[p % BANK_W] = in_sync[p];
            end
            ACC_SET, ACC_CLR: begin
                for (int p = 0; p < NUM_PINS; p++)
                    if (dec_bank == BANK_IDX_W'(p / BANK_W)) rd_next[p % BANK_W] = out_q[p];
            end
            ACC_CONST: begin
                rd_next[7:0]  = 8'(NUM_PINS);
                rd_next[15:8] = 8'(IRQ_BASE);
            end
            ACC_CFG: begin
                rd_next[FLD_OE]                  = cfg_q[dec_pin].oe;
                rd_next[FLD_INV]                 = cfg_q[dec_pin].inv;
                rd_next[FLD_OD]                  = cfg_q[dec_pin].od;
                rd_next[FLD_SEL_LO +: FLD_SEL_W] = cfg_q[dec_pin].sel;
            end
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_q <= '0;
        else if (rd_acc) rd_q <= rd_next;
    end

    // Pad drivers, one per pin
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_bank_pin u_pin (
            .cfg      (cfg_q[p]),
            .latch_bit(out_q[p]),
            .fn_out   (fn_out[p]),
            .fn_oe    (fn_oe[p]),
            .pad_out  (pad_out[p]),
            .pad_oe   (pad_oe[p])
        );
    end

    // Assertions
    assert_set_forces_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && dec_kind == ACC_SET && dec_bank == '0)
        |=> ((out_q[LOW_W-1:0] & $past(req_wdata[LOW_W-1:0])) == $past(req_wdata[LOW_W-1:0])));

    assert_clear_forces_zeros_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && dec_kind == ACC_CLR && dec_bank == '0)
        |=> ((out_q[LOW_W-1:0] & $past(req_wdata[LOW_W-1:0])) == '0));

    assert_zero_mask_keeps_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && (dec_kind == ACC_SET || dec_kind == ACC_CLR) && req_wdata == '0)
        |=> $stable(out_q));

    assert_rd_valid_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_acc));

    assert_read_gives_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rd_valid);

endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
    localparam int NP = 80;
    localparam int AW = 16;
    localparam int IB = 48;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [63:0]     req_wdata = '0;
    logic            rd_valid;
    logic [63:0]     rd_data;
    logic [NP-1:0]   pad_in = '0, pad_out, pad_oe, fn_out = '0, fn_oe = '0;

    int n_chk = 0, n_fail = 0;

    logic [NP-1:0] m_out = '0;
    logic          m_oe [NP], m_inv [NP], m_od [NP];
    logic [9:0]    m_sel [NP];

    always #2.5 clk = ~clk;

    gpio_bank #(.NUM_PINS(NP), .ADDR_W(AW), .IRQ_BASE(IB), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .fn_out(fn_out), .fn_oe(fn_oe));

    task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [NP-1:0] exp_out();
        logic [NP-1:0] e;
        for (int p = 0; p < NP; p++) begin
            if (m_sel[p] != 0)  e[p] = fn_out[p];
            else if (m_od[p])   e[p] = 1'b0;
            else                e[p] = m_out[p] ^ m_inv[p];
        end
        return e;
    endfunction

    function automatic logic [NP-1:0] exp_oe();
        logic [NP-1:0] e;
        for (int p = 0; p < NP; p++) begin
            if (m_sel[p] != 0)  e[p] = fn_oe[p];
            else if (m_od[p])   e[p] = m_oe[p] & ~(m_out[p] ^ m_inv[p]);
            else                e[p] = m_oe[p];
        end
        return e;
    endfunction

    function automatic logic [63:0] bank_of(input logic [NP-1:0] v, input int b);
        logic [63:0] r = '0;
        for (int p = 0; p < NP; p++) if (p / 64 == b) r[p % 64] = v[p];
        return r;
    endfunction

    function automatic logic [63:0] cfg_word(input int p);
        logic [63:0] r = '0;
        r[0] = m_oe[p]; r[1] = m_inv[p]; r[12] = m_od[p]; r[25:16] = m_sel[p];
        return r;
    endfunction

    // R7 R8 R9: pads against the model
    task automatic chk_pads(input string rq);
        chk({rq, " pad_out"}, 128'(pad_out), 128'(exp_out()));
        chk({rq, " pad_oe"},  128'(pad_oe),  128'(exp_oe()));
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [63:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [63:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5 rd_valid", 128'(rd_valid), 128'(1'b1));
        d = rd_data;
    endtask

    task automatic set_bank(input int b, input logic [63:0] d);
        bus_wr(AW'(b * 'h1400 + 'h8), d);
        for (int p = 0; p < NP; p++) if (p / 64 == b && d[p % 64]) m_out[p] = 1'b1;
    endtask

    task automatic clr_bank(input int b, input logic [63:0] d);
        bus_wr(AW'(b * 'h1400 + 'h10), d);
        for (int p = 0; p < NP; p++) if (p / 64 == b && d[p % 64]) m_out[p] = 1'b0;
    endtask

    task automatic cfg_pin(input int p, input logic [63:0] d);
        bus_wr(AW'('h400 + 8 * p), d);
        m_oe[p] = d[0]; m_inv[p] = d[1]; m_od[p] = d[12]; m_sel[p] = d[25:16];
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] d;
        void'($urandom(32'h6A1B));
        for (int p = 0; p < NP; p++) begin
            m_oe[p] = 0; m_inv[p] = 0; m_od[p] = 0; m_sel[p] = 0;
        end
        fn_out = {$urandom, $urandom, $urandom};
        fn_oe  = {$urandom, $urandom, $urandom};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pad_oe in reset", 128'(pad_oe), 128'(0));
        chk("R1 rd_valid in reset", 128'(rd_valid), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pad_oe after reset", 128'(pad_oe), 128'(0));
        bus_rd(16'h0008, d);     chk("R1 latch zero", 128'(d), 128'(0));
        bus_rd(16'h0428, d);     chk("R1 cfg pin5 zero", 128'(d), 128'(0));
        @(negedge clk);
        chk("R5 rd_valid drops", 128'(rd_valid), 128'(0));

        // R10: constant register
        bus_rd(16'h0090, d);     chk("R10 const", 128'(d), 128'(64'h3050));

        // R6: field placement, other bits zero
        cfg_pin(3, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_rd(16'h0418, d);     chk("R6 cfg readback", 128'(d), 128'(64'h03FF_1003));
        chk_pads("R9 fn select");
        cfg_pin(3, 0);

        // R2 R3 R4 on bank 0
        set_bank(0, 64'h0F); set_bank(0, 64'hF0);
        bus_rd(16'h0008, d);     chk("R2 set", 128'(d), 128'(64'hFF));
        clr_bank(0, 64'h3C);
        bus_rd(16'h0010, d);     chk("R3 clear", 128'(d), 128'(64'hC3));
        for (int p = 0; p < 8; p++) cfg_pin(p, 64'h1);
        set_bank(0, 0); chk_pads("R4 zero set");
        clr_bank(0, 0); chk_pads("R4 zero clear");
        bus_rd(16'h0008, d);     chk("R4 latch kept", 128'(d), 128'(64'hC3));

        // R7 R8: polarity and open drain
        cfg_pin(0, 64'h3);       chk_pads("R7 inverted push-pull");
        cfg_pin(1, 64'h1001);    chk_pads("R8 open drain high");
        cfg_pin(2, 64'h1001);    chk_pads("R8 open drain low");
        cfg_pin(4, 64'h1003);    chk_pads("R8 open drain inverted");

        // R11: second bank, unimplemented bits
        set_bank(1, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_rd(16'h1408, d);     chk("R11 bank1 width", 128'(d), 128'(64'hFFFF));
        cfg_pin(70, 64'h1);      chk_pads("R11 pin70");
        clr_bank(1, 64'h40);
        bus_rd(16'h1410, d);     chk("R11 bank1 clear bit6", 128'(d), 128'(64'hFFBF));
        chk_pads("R11 pin70 low");

        // R5: synchronized raw input, no inversion
        pad_in = {$urandom, $urandom, $urandom};
        repeat (2) @(negedge clk);
        bus_rd(16'h0000, d);     chk("R5 input bank0", 128'(d), 128'(bank_of(pad_in, 0)));
        bus_rd(16'h1400, d);     chk("R5 input bank1", 128'(d), 128'(bank_of(pad_in, 1)));

        // R12: unmapped and read-only
        bus_rd(16'h0018, d);     chk("R12 unmapped", 128'(d), 128'(0));
        bus_rd(16'h0404, d);     chk("R12 unaligned", 128'(d), 128'(0));
        bus_rd(16'h2800, d);     chk("R12 past banks", 128'(d), 128'(0));
        bus_wr(16'h0000, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_wr(16'h0090, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_wr(16'h0018, 64'hFFFF_FFFF_FFFF_FFFF);
        chk_pads("R12 ignored writes");
        bus_rd(16'h0090, d);     chk("R12 const kept", 128'(d), 128'(64'h3050));
        bus_rd(16'h0008, d);     chk("R12 latch kept", 128'(d), 128'(bank_of(m_out, 0)));

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op = int'($urandom % 6);
            int b  = int'($urandom % 2);
            int p  = int'($urandom % NP);
            logic [63:0] w = {$urandom, $urandom};
            case (op)
                0: set_bank(b, w);
                1: clr_bank(b, w);
                2, 3: begin
                    if ($urandom % 8 != 0) w[25:16] = '0;
                    cfg_pin(p, w);
                end
                4: begin
                    fn_out = {$urandom, $urandom, $urandom};
                    fn_oe  = {$urandom, $urandom, $urandom};
                    @(negedge clk);
                end
                default: begin
                    bus_rd(AW'('h400 + 8 * p), d);
                    chk("R6 random cfg", 128'(d), 128'(cfg_word(p)));
                    bus_rd(AW'(b * 'h1400 + 'h8), d);
                    chk("R2 random latch", 128'(d), 128'(bank_of(m_out, b)));
                end
            endcase
            chk_pads("R7 R8 R9 random");
        end

        summary();
        $finish;
    end

endmodule